// File: doc/BRIEF.md
# Shadow-Stack Control Register Access Checker

This block owns the 64-bit control register that governs the shadow stack for the first privileged level. It also decides what happens to each system-register read or write aimed at that register. The requester supplies five things:

- the decoded access encoding;
- the direction of the access;
- the current privilege level;
- the state of the higher levels: whether level 2 is enabled and level 3 is present, the level-3 feature enable, and its undefined-handling modes;
- the fine-grained trap permissions, the nested-virtualisation mode bits and the host-mode flag.

From these the block returns a single outcome code at once, without a clock edge. That code can be: no match, undefined, trap to level 2, trap to level 3, redirect to a memory slot, access to this register, or access to the level-2 counterpart. A trap outcome carries a syndrome class, and a redirect carries the memory offset.

The register stores five bits: two instruction-trap enables, an exception-state lock, a return-value-check enable and a call-return selection. These are driven out to the rest of the core. Every other bit reads as zero. A write updates the register on the rising clock edge, and only when the outcome is an access to this register.

The decision is a priority chain chosen by privilege level and by which of the two encodings (primary or alias) matched. In the style's terms, the outcome codes are the states of the block, and every path through the chain is a transition listed in the requirements below.

Top module: `shstk_ctl_access`

## Requirements
- R1: Only bits 9, 8, 6, 5 and 0 hold state. A read of this register returns zero in all other bits, and a write leaves them at zero.
- R2: Reset (`rst_n` low) clears every stored bit. All five field outputs then read 0.
- R3: The primary encoding is op0=3, op1=0, CRn=2, CRm=5, op2=0. The alias encoding is identical except that op1=5. Any other encoding, or `req_valid` low, gives outcome 0 (no match) and leaves the register unchanged.
- R4: Any access from level 0, through either encoding, gives outcome 1 (undefined).
- R5: Primary encoding at level 1: when level 3 is present, its undefined-priority mode is set and its feature enable is 0, the outcome is undefined. This check wins over every later check.
- R6: Primary encoding at level 1, next check: the access traps to level 2 (outcome 2) when all of the following hold:
  - level 2 is enabled;
  - fine-grained traps are implemented;
  - fine-grained traps are permitted, meaning level 3 is absent or its fine-grained enable is 1;
  - the allow bit for this direction is 0.
  Reads test `fg_rd_allow` and writes test `fg_wr_allow`; the two bits are independent.
- R7: Primary encoding at level 1, next check: when level 3 is present and its feature enable is 0, the outcome is undefined if `el3_undef_mode` is 1. Otherwise the access traps to level 3 (outcome 3).
- R8: Primary encoding at level 1, next check: when the nested-virtualisation bits equal 3'b111, the outcome is redirect (outcome 4) with offset 0x8D0, and a write does not change the register. If no check has matched, the outcome is an access to this register (outcome 5).
- R9: Primary encoding at level 2: the check of R5 applies first, then the check of R7; the fine-grained trap does not apply. If both pass, the outcome is an access to the level-2 register (outcome 6, register unchanged) when host mode is on, and outcome 5 otherwise.
- R10: Primary encoding at level 3 always gives outcome 5.
- R11: Alias encoding at level 1 is decided by the nested-virtualisation bits:
  - 3'b101 redirects to offset 0x8D0;
  - otherwise, bit 0 set traps to level 2;
  - otherwise, the outcome is undefined.
- R12: Alias encoding at levels 2 and 3 is undefined when host mode is off. At level 2 with host mode on, the checks of R5 and R7 apply and then outcome 5 follows. At level 3 with host mode on, the outcome is 5.
- R13: Outcomes 2 and 3 report syndrome class 0x18. Every other outcome reports syndrome 0. `redirect_off` is 0x8D0 only for outcome 4, and 0 otherwise.
- R14: A write with outcome 5 updates the five field outputs on the next rising edge, each from its own bit of `wdata`: bit 9 to `store_allow`, 8 to `push_allow`, 6 to `exc_lock`, 5 to `ret_check` and 0 to `call_ret_sel`. With any other outcome the field outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| enc_op0 | input | 2 | Encoding field op0 |
| enc_op1 | input | 3 | Encoding field op1 |
| enc_crn | input | 4 | Encoding field CRn |
| enc_crm | input | 4 | Encoding field CRm |
| enc_op2 | input | 3 | Encoding field op2 |
| cur_el | input | 2 | Current privilege level 0..3 |
| el2_enabled | input | 1 | Level 2 enabled for the current state |
| el3_present | input | 1 | Level 3 implemented |
| el3_undef_prio | input | 1 | Level-3 high-priority undefined mode |
| el3_undef_mode | input | 1 | Level-3 undefined (instead of trap) mode |
| el3_feat_en | input | 1 | Level-3 enable for the shadow-stack feature |
| el3_fg_en | input | 1 | Level-3 permission for fine-grained traps |
| fg_impl | input | 1 | Fine-grained traps implemented |
| fg_rd_allow | input | 1 | Read allow bit, 0 traps to level 2 |
| fg_wr_allow | input | 1 | Write allow bit, 0 traps to level 2 |
| nv_bits | input | 3 | Nested-virtualisation mode bits |
| host_mode | input | 1 | Level 2 runs as host |
| wdata | input | 64 | Write data |
| outcome | output | 3 | Outcome code 0..6 |
| syndrome | output | 6 | Trap syndrome class |
| redirect_off | output | 12 | Memory offset for a redirect |
| rdata | output | 64 | Register value for a local read, else 0 |
| store_allow | output | 1 | Stored bit 9 |
| push_allow | output | 1 | Stored bit 8 |
| exc_lock | output | 1 | Stored bit 6 |
| ret_check | output | 1 | Stored bit 5 |
| call_ret_sel | output | 1 | Stored bit 0 |

## Verification
The bench builds the block with its default parameters: a 64-bit data path, the field mask 0x361, syndrome class 0x18 and offset 0x8D0. With these values, every reserved bit above bit 9 can be written with ones and observed to read back as zero, and the redirect and trap reports can be compared with their exact codes. The vector table steps each privilege level through both encodings. It sets the level-3, fine-grained and nested-virtualisation inputs so that each rung of the priority chain is reached, and also the case where two rungs both apply and the earlier one must win.

// File: rtl/shstk_pkg.sv
package shstk_pkg;

    typedef enum logic [2:0] {
        OUT_NONE     = 3'd0,
        OUT_UNDEF    = 3'd1,
        OUT_TRAP_L2  = 3'd2,
        OUT_TRAP_L3  = 3'd3,
        OUT_REDIRECT = 3'd4,
        OUT_LOCAL    = 3'd5,
        OUT_HOST_REG = 3'd6
    } outcome_e;

    // Field positions; the core decodes these bits from reads
    localparam int BIT_STORE = 9;
    localparam int BIT_PUSH  = 8;
    localparam int BIT_LOCK  = 6;
    localparam int BIT_RCHK  = 5;
    localparam int BIT_CRSEL = 0;

endpackage

// File: rtl/shstk_enc_match.sv
module shstk_enc_match #(
    parameter logic [1:0] OP0     = 2'b11,
    parameter logic [2:0] OP1_PRI = 3'b000,
    parameter logic [2:0] OP1_ALI = 3'b101,
    parameter logic [3:0] CRN     = 4'b0010,
    parameter logic [3:0] CRM     = 4'b0101,
    parameter logic [2:0] OP2     = 3'b000
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit_primary,
    output logic       hit_alias
);
    logic common_hit;

    always_comb begin
        common_hit  = (op0 == OP0) && (crn == CRN) && (crm == CRM) && (op2 == OP2);
        hit_primary = common_hit && (op1 == OP1_PRI);
        hit_alias   = common_hit && (op1 == OP1_ALI);
    end
endmodule

// File: rtl/shstk_access_arbiter.sv
module shstk_access_arbiter
    import shstk_pkg::*;
#(
    parameter logic [2:0] NV_REDIR_PRI = 3'b111,
    parameter logic [2:0] NV_REDIR_ALI = 3'b101
) (
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       hit_primary,
    input  logic       hit_alias,
    input  logic [1:0] cur_el,
    input  logic       el2_enabled,
    input  logic       el3_present,
    input  logic       el3_undef_prio,
    input  logic       el3_undef_mode,
    input  logic       el3_feat_en,
    input  logic       el3_fg_en,
    input  logic       fg_impl,
    input  logic       fg_rd_allow,
    input  logic       fg_wr_allow,
    input  logic [2:0] nv_bits,
    input  logic       host_mode,
    output outcome_e   result
);
    logic     hard_undef;
    logic     l3_block;
    outcome_e l3_block_res;
    logic     fg_trap;

    always_comb begin
        hard_undef   = el3_present && el3_undef_prio && !el3_feat_en;
        l3_block     = el3_present && !el3_feat_en;
        l3_block_res = el3_undef_mode ? OUT_UNDEF : OUT_TRAP_L3;
        fg_trap      = el2_enabled && fg_impl && (!el3_present || el3_fg_en)
                       && !(req_write ? fg_wr_allow : fg_rd_allow);
    end

    always_comb begin
        result = OUT_NONE;
        if (req_valid && hit_primary) begin
            unique case (cur_el)
                2'd0: result = OUT_UNDEF;
                2'd1: begin
                    if (hard_undef)                 result = OUT_UNDEF;
                    else if (fg_trap)               result = OUT_TRAP_L2;
                    else if (l3_block)              result = l3_block_res;
                    else if (nv_bits == NV_REDIR_PRI) result = OUT_REDIRECT;
                    else                            result = OUT_LOCAL;
                end
                2'd2: begin
                    if (hard_undef)     result = OUT_UNDEF;
                    else if (l3_block)  result = l3_block_res;
                    else if (host_mode) result = OUT_HOST_REG;
                    else                result = OUT_LOCAL;
                end
                2'd3: result = OUT_LOCAL;
            endcase
        end else if (req_valid && hit_alias) begin
            unique case (cur_el)
                2'd0: result = OUT_UNDEF;
                2'd1: begin
                    if (nv_bits == NV_REDIR_ALI) result = OUT_REDIRECT;
                    else if (nv_bits[0])         result = OUT_TRAP_L2;
                    else                         result = OUT_UNDEF;
                end
                2'd2: begin
                    if (!host_mode)     result = OUT_UNDEF;
                    else if (hard_undef) result = OUT_UNDEF;
                    else if (l3_block)  result = l3_block_res;
                    else                result = OUT_LOCAL;
                end
                2'd3: result = host_mode ? OUT_LOCAL : OUT_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/shstk_field_store.sv
module shstk_field_store #(
    parameter int              DATA_W = 64,
    parameter logic [DATA_W-1:0] MASK = 64'h0000_0000_0000_0361
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (MASK[i]) begin : g_live
            logic q;
            always_ff @(posedge clk) begin
                if (!rst_n)     q <= 1'b0;
                else if (wr_en) q <= wdata[i];
            end
            assign value[i] = q;
        end else begin : g_rsv
            assign value[i] = 1'b0;
        end
    end
endmodule

// File: rtl/shstk_ctl_access.sv
module shstk_ctl_access
    import shstk_pkg::*;
#(
    parameter int               DATA_W   = 64,
    parameter logic [DATA_W-1:0] FLD_MASK = 64'h0000_0000_0000_0361,
    parameter logic [5:0]       EC_CLASS = 6'h18,
    parameter logic [11:0]      NV_OFF   = 12'h8D0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        enc_op0,
    input  logic [2:0]        enc_op1,
    input  logic [3:0]        enc_crn,
    input  logic [3:0]        enc_crm,
    input  logic [2:0]        enc_op2,
    input  logic [1:0]        cur_el,
    input  logic              el2_enabled,
    input  logic              el3_present,
    input  logic              el3_undef_prio,
    input  logic              el3_undef_mode,
    input  logic              el3_feat_en,
    input  logic              el3_fg_en,
    input  logic              fg_impl,
    input  logic              fg_rd_allow,
    input  logic              fg_wr_allow,
    input  logic [2:0]        nv_bits,
    input  logic              host_mode,
    input  logic [DATA_W-1:0] wdata,
    output logic [2:0]        outcome,
    output logic [5:0]        syndrome,
    output logic [11:0]       redirect_off,
    output logic [DATA_W-1:0] rdata,
    output logic              store_allow,
    output logic              push_allow,
    output logic              exc_lock,
    output logic              ret_check,
    output logic              call_ret_sel
);
    logic              hit_pri;
    logic              hit_ali;
    outcome_e          res;
    logic              commit;
    logic [DATA_W-1:0] reg_val;

    shstk_enc_match u_match (
        .op0(enc_op0), .op1(enc_op1), .crn(enc_crn), .crm(enc_crm), .op2(enc_op2),
        .hit_primary(hit_pri), .hit_alias(hit_ali)
    );

    shstk_access_arbiter u_arb (
        .req_valid(req_valid), .req_write(req_write),
        .hit_primary(hit_pri), .hit_alias(hit_ali), .cur_el(cur_el),
        .el2_enabled(el2_enabled), .el3_present(el3_present),
        .el3_undef_prio(el3_undef_prio), .el3_undef_mode(el3_undef_mode),
        .el3_feat_en(el3_feat_en), .el3_fg_en(el3_fg_en), .fg_impl(fg_impl),
        .fg_rd_allow(fg_rd_allow), .fg_wr_allow(fg_wr_allow),
        .nv_bits(nv_bits), .host_mode(host_mode), .result(res)
    );

    assign commit = req_write && (res == OUT_LOCAL);

    shstk_field_store #(.DATA_W(DATA_W), .MASK(FLD_MASK)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(commit), .wdata(wdata), .value(reg_val)
    );

    always_comb begin
        outcome      = res;
        syndrome     = '0;
        redirect_off = '0;
        rdata        = '0;
        unique case (res)
            OUT_TRAP_L2, OUT_TRAP_L3: syndrome     = EC_CLASS;
            OUT_REDIRECT:             redirect_off = NV_OFF;
            OUT_LOCAL:                rdata        = req_write ? '0 : reg_val;
            default: ;
        endcase
        store_allow  = reg_val[BIT_STORE];
        push_allow   = reg_val[BIT_PUSH];
        exc_lock     = reg_val[BIT_LOCK];
        ret_check    = reg_val[BIT_RCHK];
        call_ret_sel = reg_val[BIT_CRSEL];
    end
endmodule

// File: rtl/shstk_ctl_access_chk.sv
module shstk_ctl_access_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        cur_el,
    input logic [DATA_W-1:0] wdata,
    input logic [2:0]        outcome,
    input logic [5:0]        syndrome,
    input logic [11:0]       redirect_off,
    input logic [DATA_W-1:0] rdata,
    input logic [4:0]        fields
);
    logic [4:0] wfld;
    assign wfld = {wdata[9], wdata[8], wdata[6], wdata[5], wdata[0]};

    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~64'h361) == '0); // R1
    AST_L0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_el == 2'd0 && outcome != 3'd0) |-> outcome == 3'd1); // R4
    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome == 3'd2 || outcome == 3'd3) |-> syndrome == 6'h18); // R13
    AST_REDIR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome == 3'd4) |-> redirect_off == 12'h8D0); // R8
    AST_NO_L2TRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_el == 2'd3) |-> outcome != 3'd2); // R12
    AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> outcome == 3'd0); // R3
    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_write && outcome == 3'd5) |=> $stable(fields)); // R14
    AST_COMMIT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_write && outcome == 3'd5) |=> fields == $past(wfld)); // R14
endmodule

bind shstk_ctl_access shstk_ctl_access_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .cur_el(cur_el), .wdata(wdata), .outcome(outcome), .syndrome(syndrome),
    .redirect_off(redirect_off), .rdata(rdata),
    .fields({store_allow, push_allow, exc_lock, ret_check, call_ret_sel})
);

// File: tb/shstk_ctl_access_tb.sv
module shstk_ctl_access_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  enc_op0 = 2'd3;
    logic [2:0]  enc_op1 = 3'd0;
    logic [3:0]  enc_crn = 4'd2, enc_crm = 4'd5;
    logic [2:0]  enc_op2 = 3'd0;
    logic [1:0]  cur_el = 2'd0;
    logic        el2_enabled = 1'b1, el3_present = 1'b1, el3_undef_prio = 1'b0;
    logic        el3_undef_mode = 1'b0, el3_feat_en = 1'b1, el3_fg_en = 1'b1;
    logic        fg_impl = 1'b1, fg_rd_allow = 1'b1, fg_wr_allow = 1'b1;
    logic [2:0]  nv_bits = 3'd0;
    logic        host_mode = 1'b0;
    logic [63:0] wdata = '0;
    logic [2:0]  outcome;
    logic [5:0]  syndrome;
    logic [11:0] redirect_off;
    logic [63:0] rdata;
    logic        store_allow, push_allow, exc_lock, ret_check, call_ret_sel;
    int          n_vec = 0, n_bad = 0;

    always #4 clk = ~clk;

    shstk_ctl_access u_dut (.*);

    // [27:24] req  [23:22] level  [21] write  [20] alias  [19] l2en  [18] l3 present
    // [17] undef prio  [16] undef mode  [15] feat en  [14] l3 fg en  [13] fg impl
    // [12] rd allow  [11] wr allow  [10:8] nv  [7] host  [6:4] expected outcome
    function automatic logic [27:0] v(int rq, int el, bit wr, bit al, bit l2e, bit l3p,
        bit up, bit um, bit fe, bit f3, bit fi, bit rn, bit wn, int nv, bit hs, int ex);
        return {rq[3:0], el[1:0], wr, al, l2e, l3p, up, um, fe, f3, fi, rn, wn,
                nv[2:0], hs, ex[2:0], 4'd0};
    endfunction

    localparam int NV = 25;
    localparam logic [27:0] VEC [NV] = '{
        v(4, 0,0,0, 1,1,0,0,1,1,1,1,1, 0,0, 1),  // R4 primary read
        v(4, 0,1,1, 1,1,0,0,1,1,1,1,1, 0,1, 1),  // R4 alias write
        v(5, 1,0,0, 1,1,1,0,0,1,1,0,1, 0,0, 1),  // R5 beats fg trap
        v(6, 1,0,0, 1,1,0,0,1,1,1,0,1, 0,0, 2),  // R6 read trapped
        v(6, 1,0,0, 1,1,0,0,1,1,1,1,0, 0,0, 5),  // R6 write bit ignored on read
        v(6, 1,1,0, 1,1,0,0,1,1,1,1,0, 0,0, 2),  // R6 write trapped
        v(6, 1,0,0, 1,1,0,0,1,0,1,0,1, 0,0, 5),  // R6 l3 forbids fg
        v(6, 1,0,0, 1,0,0,0,0,0,1,0,1, 0,0, 2),  // R6 l3 absent permits fg
        v(6, 1,0,0, 0,1,0,0,1,1,1,0,1, 0,0, 5),  // R6 l2 disabled
        v(7, 1,0,0, 1,1,0,1,0,1,1,1,1, 0,0, 1),  // R7 undef mode
        v(7, 1,1,0, 1,1,0,0,0,1,1,1,1, 0,0, 3),  // R7 trap to l3
        v(8, 1,1,0, 1,1,0,0,1,1,1,1,1, 7,0, 4),  // R8 redirect write
        v(7, 1,0,0, 1,1,0,0,0,1,1,1,1, 7,0, 3),  // R7 beats redirect
        v(9, 2,1,0, 1,1,0,0,1,1,1,1,1, 0,1, 6),  // R9 host rename
        v(9, 2,0,0, 1,1,0,0,1,1,1,0,1, 0,0, 5),  // R9 no fg at l2
        v(9, 2,1,0, 1,1,1,0,0,1,1,1,1, 0,1, 1),  // R9 l3 undef first
        v(10,3,0,0, 1,1,1,0,0,1,1,0,0, 7,0, 5),  // R10 always local
        v(11,1,1,1, 1,1,0,0,1,1,1,1,1, 5,0, 4),  // R11 alias redirect
        v(11,1,0,1, 1,1,0,0,1,1,1,1,1, 7,0, 2),  // R11 nv bit0
        v(11,1,1,1, 1,1,0,0,1,1,1,1,1, 1,0, 2),  // R11 nv bit0
        v(11,1,0,1, 1,1,0,0,1,1,1,1,1, 6,0, 1),  // R11 undef
        v(12,2,1,1, 1,1,0,0,1,1,1,1,1, 0,0, 1),  // R12 no host
        v(12,2,1,1, 1,1,0,0,0,1,1,1,1, 0,1, 3),  // R12 host, l3 trap
        v(12,3,1,1, 1,1,0,0,1,1,1,1,1, 0,0, 1),  // R12 l3 no host
        v(12,3,0,1, 1,1,0,0,1,1,1,1,1, 0,1, 5)   // R12 l3 host read
    };

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [27:0] e, logic [63:0] d);
        cur_el = e[23:22]; req_write = e[21]; enc_op1 = e[20] ? 3'd5 : 3'd0;
        el2_enabled = e[19]; el3_present = e[18]; el3_undef_prio = e[17];
        el3_undef_mode = e[16]; el3_feat_en = e[15]; el3_fg_en = e[14];
        fg_impl = e[13]; fg_rd_allow = e[12]; fg_wr_allow = e[11];
        nv_bits = e[10:8]; host_mode = e[7]; wdata = d; req_valid = 1'b1;
    endtask

    function automatic logic [4:0] flds();
        return {store_allow, push_allow, exc_lock, ret_check, call_ret_sel};
    endfunction

    // one request: drive after negedge, sample outcome, let edge pass, sample fields
    task automatic step(logic [27:0] e, logic [63:0] d, string tag, int ex, logic [4:0] fexp);
        @(negedge clk); drive(e, d); #1;
        chk(tag, outcome, ex);
        @(negedge clk); req_valid = 1'b0;
        chk(tag, flds(), fexp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2 reset fields", flds(), 5'd0);
        chk("R3 idle outcome", outcome, 3'd0);

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d vec%0d", VEC[i][27:24], i);
            @(negedge clk); drive(VEC[i], '1); #1;
            chk(tg, outcome, VEC[i][6:4]);
            chk({tg, " R13 syndrome"}, syndrome,
                (VEC[i][6:4] == 3'd2 || VEC[i][6:4] == 3'd3) ? 6'h18 : 6'h0);
            chk({tg, " R13 offset"}, redirect_off, (VEC[i][6:4] == 3'd4) ? 12'h8D0 : 12'h0);
            if (VEC[i][6:4] == 3'd5 && !VEC[i][21]) chk({tg, " rdata"}, rdata, 64'h0);
            @(negedge clk); req_valid = 1'b0;
            chk({tg, " fields unchanged"}, flds(), 5'd0);
        end

        // R1 R14 write all ones at level 3, read back
        step(v(1, 3,1,0, 1,1,0,0,1,1,1,1,1, 0,0, 5), '1, "R14 write ones", 5, 5'b11111);
        @(negedge clk); drive(v(1, 3,0,0, 1,1,0,0,1,1,1,1,1, 0,0, 5), '0); #1;
        chk("R1 readback", rdata, 64'h361);
        @(negedge clk); req_valid = 1'b0;
        // R3 non-matching encoding ignores a write
        @(negedge clk); drive(v(3, 3,1,0, 1,1,0,0,1,1,1,1,1, 0,0, 5), '0);
        enc_crm = 4'd6; #1;
        chk("R3 no match", outcome, 3'd0);
        @(negedge clk); req_valid = 1'b0; enc_crm = 4'd5;
        chk("R3 fields kept", flds(), 5'b11111);
        // R3 invalid request ignores a write
        @(negedge clk); drive(v(3, 3,1,0, 1,1,0,0,1,1,1,1,1, 0,0, 5), '0);
        req_valid = 1'b0; #1;
        chk("R3 idle", outcome, 3'd0);
        @(negedge clk);
        chk("R3 idle fields", flds(), 5'b11111);
        // R8 redirect write and R9 host write leave register alone
        step(v(8, 1,1,0, 1,1,0,0,1,1,1,1,1, 7,0, 4), '0, "R8 redirect keeps", 4, 5'b11111);
        step(v(9, 2,1,0, 1,1,0,0,1,1,1,1,1, 0,1, 6), '0, "R9 host keeps", 6, 5'b11111);
        // R12 R14 alias write from level 2 host: bits 9,5,0
        step(v(12, 2,1,1, 1,1,0,0,1,1,1,1,1, 0,1, 5), 64'hFFFF_0000_0000_0221,
             "R14 alias write", 5, 5'b10011);
        // R9 level 2 without host reaches this register
        step(v(9, 2,1,0, 1,1,0,0,1,1,1,1,1, 0,0, 5), 64'h140, "R9 local write", 5, 5'b01100);
        // R2 reset clears again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R2 re-reset", flds(), 5'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule